// File: doc/BRIEF.md
# Shared PWM Generator Bank

This block holds eight square-wave generators and a routing stage that lets sixteen output pins share them. Each generator has a period value and a high/low step split. Each pin picks one generator with a 3-bit index and is gated by its own enable bit. A word-wide write port with byte enables programs the generators and the routing. A combinational read port returns any configuration word. Software keeps the high count as the duty value and the low count as its complement to 255. The output is then high for that share of every period.

A base tick strobe comes from outside the block and lasts one cycle. Each generator divides its period into 255 steps, and each step lasts P ticks, where P is the effective period value. With a tick of 1/63750 s, one period is P/250 s. Values written to a generator are held in its configuration registers. They are loaded into the running copy only when the current period ends. Routing changes act at once. Clearing a pin's enable bit forces only that pin low.

Top module: `pwm_gen_bank`

## Requirements
- R1: After reset every pin is low and every configuration word reads 0.
- R2: A write updates only the bytes whose `wr_be` bit is set. Reading any word address returns its stored value. The word map is: 0 holds routing for pins 0-7, 1 holds routing for pins 8-15, 2 holds periods of generators 0-3, 3 holds periods of generators 4-7, and 4-7 each hold the high/low pair of two generators.
- R3: Pin p uses nibble p mod 8 of routing word p/8. Nibble bits [2:0] select the generator and bit 3 enables the pin. A disabled pin is low.
- R4: Generator n takes its period from byte n mod 4 of its period word. It takes its high count from bits 16·(n mod 2)+[7:0] and its low count from 16·(n mod 2)+[15:8] of its pair word. A period is 255 steps of P ticks each. The output is high while the step number is below the high count and low otherwise.
- R5: A low count of 0 gives a constant high output, and this takes priority over the high count. Otherwise a high count of 0 gives a constant low output.
- R6: A period value of 0 acts as 1, and a value above 250 acts as 250.
- R7: New generator settings take effect only at the end of the running period. The period in progress completes with the old values.
- R8: A write landing on the same clock edge as a period boundary is deferred. The next period still runs with the old values, and the new values start one period later.
- R9: Clearing a pin's enable bit drives that pin low on the next cycle. Other pins on the same generator keep their waveform.
- R10: Changing a pin's generator index switches its output in the cycle after the write.
- R11: Generators advance only on cycles where `tick` is high. Without ticks their outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Base tick strobe, one cycle wide |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write word address |
| wr_data | input | 32 | Write data |
| wr_be | input | 4 | Byte enables for the write |
| rd_addr | input | 3 | Read word address |
| rd_data | output | 32 | Read data, combinational |
| pin_out | output | 16 | Routed PWM outputs |

## Verification
Two functions can fall on the same edge: a configuration write and the period boundary of the generator being written. To make them coincide, the bench uses a generator with period 1, high count 254 and low count 1. Its single low cycle marks step 254, so the bench raises the write strobe on the falling clock edge where it sees that low cycle. The write and the boundary then share the next rising edge. The bench passes if the following high run still lasts 254 cycles and the run after the next low cycle lasts the new 10 cycles.

// File: rtl/pwm_gen_bank.sv
module pwm_gen_bank #(
  parameter int NPIN    = 16,
  parameter int PER_MAX = 250,
  localparam int NGEN   = 8,
  localparam int RW     = NPIN / 8,
  localparam int NW     = RW + 6,
  localparam int AW     = $clog2(NW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [31:0]     wr_data,
  input  logic [3:0]      wr_be,
  input  logic [AW-1:0]   rd_addr,
  output logic [31:0]     rd_data,
  output logic [NPIN-1:0] pin_out
);

  localparam logic [7:0] LAST = 8'd254;
  localparam int PB = RW;
  localparam int HB = RW + 2;

  logic [NW-1:0][31:0]  regs_q;
  logic [NGEN-1:0][7:0] per_w, hi_w, lo_w;
  logic [NGEN-1:0][7:0] act_per_q, act_hi_q, act_lo_q;
  logic [NGEN-1:0][7:0] pre_q, step_q, eff_per;
  logic [NGEN-1:0]      step_end, bnd, gen_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs_q <= '0;
    end else if (wr_en) begin
      for (int w = 0; w < NW; w++)
        if (wr_addr == AW'(w))
          for (int b = 0; b < 4; b++)
            if (wr_be[b]) regs_q[w][8*b +: 8] <= wr_data[8*b +: 8];
    end
  end

  assign rd_data = (int'(rd_addr) < NW) ? regs_q[rd_addr] : '0;

  always_comb begin
    for (int g = 0; g < NGEN; g++) begin
      per_w[g]    = regs_q[PB + g/4][8*(g%4) +: 8];
      hi_w[g]     = regs_q[HB + g/2][16*(g%2) +: 8];
      lo_w[g]     = regs_q[HB + g/2][16*(g%2) + 8 +: 8];
      eff_per[g]  = (act_per_q[g] == 8'd0) ? 8'd1 :
                    (act_per_q[g] > 8'(PER_MAX)) ? 8'(PER_MAX) : act_per_q[g];
      step_end[g] = pre_q[g] >= eff_per[g] - 8'd1;
      bnd[g]      = tick && step_end[g] && step_q[g] == LAST;
      gen_out[g]  = (act_lo_q[g] == 8'd0) || (step_q[g] < act_hi_q[g]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q     <= '0;
      step_q    <= '0;
      act_per_q <= '0;
      act_hi_q  <= '0;
      act_lo_q  <= '0;
    end else if (tick) begin
      for (int g = 0; g < NGEN; g++) begin
        if (step_end[g]) begin
          pre_q[g] <= '0;
          if (step_q[g] == LAST) begin
            step_q[g]    <= '0;
            act_per_q[g] <= per_w[g];
            act_hi_q[g]  <= hi_w[g];
            act_lo_q[g]  <= lo_w[g];
          end else begin
            step_q[g] <= step_q[g] + 8'd1;
          end
        end else begin
          pre_q[g] <= pre_q[g] + 8'd1;
        end
      end
    end
  end

  always_comb begin
    for (int p = 0; p < NPIN; p++) begin
      logic [3:0] nib;
      nib = regs_q[p/8][4*(p%8) +: 4];
      pin_out[p] = nib[3] & gen_out[nib[2:0]];
    end
  end

endmodule

// File: rtl/pwm_gen_bank_chk.sv
module pwm_gen_bank_chk #(
  parameter int NPIN    = 16,
  parameter int PER_MAX = 250
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tick,
  input logic [NPIN-1:0] pin_out,
  input logic [7:0]      gen_out,
  input logic [7:0]      bnd,
  input logic [63:0]     act_hi,
  input logic [63:0]     eff_per,
  input logic [63:0]     step
);

  a_r1_reset_pins_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> pin_out == '0);

  a_r11_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(gen_out));

  for (genvar g = 0; g < 8; g++) begin : g_gen
    a_r7_apply_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      (act_hi[8*g +: 8] != $past(act_hi[8*g +: 8])) |-> $past(bnd[g]));

    a_r6_period_range: assert property (@(posedge clk) disable iff (!rst_n)
      eff_per[8*g +: 8] >= 8'd1 && eff_per[8*g +: 8] <= 8'(PER_MAX));

    a_r4_step_range: assert property (@(posedge clk) disable iff (!rst_n)
      step[8*g +: 8] <= 8'd254);
  end

endmodule

bind pwm_gen_bank pwm_gen_bank_chk #(.NPIN(NPIN), .PER_MAX(PER_MAX)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick), .pin_out(pin_out),
  .gen_out(gen_out), .bnd(bnd), .act_hi(act_hi_q), .eff_per(eff_per),
  .step(step_q)
);

// File: tb/pwm_gen_bank_tb.sv
module pwm_gen_bank_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  wr_be = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [15:0] pin_out;

  always #2.5 clk = ~clk;

  pwm_gen_bank dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_be(wr_be), .rd_addr(rd_addr), .rd_data(rd_data),
    .pin_out(pin_out)
  );

  typedef struct {
    int          kind;
    logic [31:0] mask;
    logic [31:0] act;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  event  sb_ev;
  int    checks = 0;
  int    errors = 0;
  bit    done = 0;

  initial forever begin
    @(sb_ev);
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] a;
      it = q.pop_front();
      case (it.kind)
        0:       a = {16'h0, pin_out} & it.mask;
        1:       a = rd_data;
        default: a = it.act;
      endcase
      checks++;
      if (a !== it.exp) begin
        errors++;
        $display("FAIL %s actual=%0h expected=%0h", it.tag, a, it.exp);
      end
    end
  end

  task automatic push(input int kind, input logic [31:0] mask, input logic [31:0] act,
                      input logic [31:0] exp, input string tag);
    item_t it;
    it.kind = kind; it.mask = mask; it.act = act; it.exp = exp; it.tag = tag;
    q.push_back(it);
    -> sb_ev;
  endtask

  task automatic exp_pins(input logic [15:0] mask, input logic [15:0] exp, input string tag);
    push(0, {16'h0, mask}, '0, {16'h0, exp}, tag);
  endtask

  task automatic exp_rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    rd_addr = a;
    #1;
    push(1, '1, '0, exp, tag);
    #1;
  endtask

  task automatic exp_val(input int act, input int exp, input string tag);
    push(2, '1, act, exp, tag);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic [3:0] be);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = a; wr_data = d; wr_be = be;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic wait_level(input int pin, input logic lvl);
    do @(negedge clk); while (pin_out[pin] !== lvl);
  endtask

  task automatic run_after(input int pin, input logic lvl, output int n);
    bit go;
    n = 0; go = 1;
    while (go) begin
      @(negedge clk);
      if (pin_out[pin] === lvl) n++; else go = 0;
    end
  endtask

  task automatic count_level(input int pin, input int cyc, output int n);
    n = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (pin_out[pin] === 1'b1) n++;
    end
  endtask

  task automatic count_edges(input int pin, input int cyc, output int n);
    logic prev;
    n = 0; prev = pin_out[pin];
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (pin_out[pin] !== prev) n++;
      prev = pin_out[pin];
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hang expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    exp_pins(16'hFFFF, 16'h0, "R1 pins low after reset");
    for (int w = 0; w < 8; w++) exp_rd(3'(w), 32'h0, "R1 word reads zero");

    wr(3'd4, 32'hAABBCCDD, 4'b0101);
    exp_rd(3'd4, 32'h00BB00DD, "R2 byte mask low bytes");
    wr(3'd4, 32'h11223344, 4'b1010);
    exp_rd(3'd4, 32'h11BB33DD, "R2 byte mask high bytes");
    wr(3'd4, 32'h0, 4'b1111);

    wr(3'd2, 32'h00000002, 4'b0001);
    wr(3'd4, 32'h00009B64, 4'b0011);
    wr(3'd0, 32'h00000088, 4'b0001);
    exp_rd(3'd0, 32'h00000088, "R3 routing word 0 readback");
    exp_rd(3'd2, 32'h00000002, "R2 period word readback");
    repeat (2000) @(posedge clk);

    wait_level(0, 1'b0); wait_level(0, 1'b1);
    run_after(0, 1'b1, n); exp_val(n + 1, 200, "R4 high run 100 steps x2");
    run_after(0, 1'b0, n); exp_val(n + 1, 310, "R4 low run 155 steps x2");

    wr(3'd0, 32'h00000008, 4'b0001);
    exp_pins(16'h0002, 16'h0, "R9 disabled pin low");
    wait_level(0, 1'b0); wait_level(0, 1'b1);
    run_after(0, 1'b1, n); exp_val(n + 1, 200, "R9 shared pin undisturbed");

    wait_level(0, 1'b1);
    wr(3'd4, 32'h0000CD32, 4'b0011);
    run_after(0, 1'b1, n); exp_val(n + 2, 200, "R7 running period keeps old high");
    run_after(0, 1'b0, n); exp_val(n + 1, 310, "R7 running period keeps old low");
    run_after(0, 1'b1, n); exp_val(n + 1, 100, "R7 new high after boundary");
    run_after(0, 1'b0, n); exp_val(n + 1, 410, "R7 new low after boundary");

    wr(3'd4, 32'h00FF0000, 4'b1100);
    wr(3'd5, 32'h0000FF00, 4'b0011);
    wr(3'd0, 32'h00000900, 4'b0010);
    repeat (600) @(posedge clk);
    count_level(2, 300, n); exp_val(n, 300, "R5 low count 0 constant high");
    @(negedge clk);
    exp_pins(16'h0004, 16'h0004, "R10 pin on first generator");
    wr(3'd0, 32'h00000A00, 4'b0010);
    exp_pins(16'h0004, 16'h0, "R10 index change immediate");
    count_level(2, 300, n); exp_val(n, 0, "R5 high count 0 constant low");

    @(negedge clk); tick = 1'b0;
    count_edges(0, 1000, n); exp_val(n, 0, "R11 no ticks output holds");
    @(negedge clk); tick = 1'b1;
    count_edges(0, 2000, n); exp_val(n > 0, 1, "R11 resumes with ticks");

    wr(3'd5, 32'hFE010000, 4'b1100);
    wr(3'd2, 32'hFF000000, 4'b1000);
    wr(3'd0, 32'h0000BA00, 4'b0010);
    wait_level(3, 1'b0); wait_level(3, 1'b1);
    run_after(3, 1'b1, n); exp_val(n + 1, 250, "R6 period above max clamps to 250");

    wr(3'd6, 32'h0000FE01, 4'b0011);
    wr(3'd1, 32'h0000000C, 4'b0001);
    exp_rd(3'd1, 32'h0000000C, "R3 pin 8 in routing word 1");
    repeat (600) @(posedge clk);
    wait_level(8, 1'b0); wait_level(8, 1'b1);
    run_after(8, 1'b1, n); exp_val(n + 1, 1, "R6 period 0 acts as 1");
    run_after(8, 1'b0, n); exp_val(n + 1, 254, "R4 low run 254 steps");

    wr(3'd6, 32'h01FE0000, 4'b1100);
    wr(3'd1, 32'h000000DC, 4'b0001);
    repeat (600) @(posedge clk);
    wait_level(9, 1'b0);
    wr_en = 1'b1; wr_addr = 3'd6; wr_data = 32'hF50A0000; wr_be = 4'b1100;
    @(posedge clk); #1 wr_en = 1'b0;
    run_after(9, 1'b1, n); exp_val(n, 254, "R8 write on boundary deferred");
    run_after(9, 1'b0, n); exp_val(n + 1, 1, "R8 old low kept");
    run_after(9, 1'b1, n); exp_val(n + 1, 10, "R8 new high one period later");

    repeat (5) @(posedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule